// File: doc/BRIEF.md
# Baud Rate Reload Down-Timer

This block generates the internal bit-rate clock for a serial receiver/transmitter. A down-counter is decremented by an external count-enable tick. When it steps below zero it is refilled from a software-held reload value, a sticky underflow flag is set, and a flip-flop that drives the baud clock toggles. A reload value N therefore gives a baud clock period of 2·(N+1) ticks.

Software uses a small register port with three locations. Address 0 holds the reload value (read/write). Address 1 returns the live counter (read-only). Address 2 is the control word. Its bit 0 is run, bit 1 is an active-low clear strobe, and bit 2 is the underflow flag. Bits 3 and 4 are reserved.

When several events meet in the same clock cycle, a fixed order decides the result. A clear beats counting and refilling. A hardware flag set beats a software flag clear. A reload value written in the same cycle as a refill only takes effect at the next refill.

Top module: `baud_reload_timer`

## Requirements
- R1: After reset the reload value, the counter, the flag and the baud clock are all 0, and the timer is stopped.
- R2: While running, each tick lowers the counter by 1. A tick at counter 0 instead loads the reload value, toggles baud_clk and sets the flag. The baud period is 2·(N+1) ticks.
- R3: A control write with bit 0 = 1 and bit 1 = 1, while stopped, loads the counter from the reload register on the next cycle.
- R4: A control write with bit 0 = 0 stops the timer. The counter then holds its value and can still be read at address 1.
- R5: A control write with bit 1 = 0 sets the counter and baud_clk to 0 on the next cycle. This holds even if a count or a refill would have happened in that cycle.
- R6: Writing bit 0 = 1 and bit 1 = 0 together while stopped clears the counter and starts the timer. The very next tick underflows: the counter takes the reload value, the flag becomes 1 and baud_clk becomes 1.
- R7: Any control write with bit 2 = 0 clears the flag. Writing bit 2 = 1 leaves the flag as it is. If an underflow falls in the same cycle as a clearing write, the flag ends at 1.
- R8: If address 0 is written in the same cycle as a refill, the counter takes the previous reload value. The new value is used from the next refill on.
- R9: Reading the control word returns run in bit 0, 1 in bit 1 and the flag in bit 2. Bits 3 and 4, and all bits above them, read as 0. Values written to bits 3 and 4 have no effect.
- R10: While the timer is stopped, ticks have no effect on the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | CNT_W | Write data |
| tick | input | 1 | Count-enable pulse |
| rdata | output | CNT_W | Read data (combinational on addr) |
| baud_clk | output | 1 | Baud clock from the toggle flip-flop |
| uflow_flag | output | 1 | Sticky underflow flag |

## Verification
The bench makes each collision happen by driving a write and a tick in the same cycle, at the moment the counter is at 0. It covers three such pairs: a clear meeting a refill, a flag-clearing write meeting a refill, and a reload-register write meeting a refill. After the edge it checks the counter and the flag, and later the next refill value, against what the priority rules predict. For reload values 0 to 7 it also checks the counter and baud clock after every tick against the closed forms N − (k mod (N+1)) and ⌊k/(N+1)⌋ mod 2.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_RELOAD = 2'd0;
  localparam logic [ADDR_W-1:0] A_COUNT  = 2'd1;
  localparam logic [ADDR_W-1:0] A_CTRL   = 2'd2;

  // control word bit positions
  localparam int B_RUN  = 0;
  localparam int B_CLRN = 1;
  localparam int B_FLAG = 2;

  typedef struct packed {
    logic clear;   // counter and toggle flip-flop forced to zero
    logic load;    // start from stopped: fill from reload register
  } core_cmd_t;
endpackage

// File: rtl/timer_rst_sync.sv
module timer_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/timer_regs.sv
module timer_regs
  import timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  input  logic              underflow,
  output logic [CNT_W-1:0]  reload_q,
  output logic              run_q,
  output logic              flag_q,
  output core_cmd_t         cmd
);
  logic             ctrl_wr;
  logic             reload_wr;
  logic [CNT_W-1:0] reload_d;
  logic             run_d;
  logic             flag_d;

  always_comb begin
    ctrl_wr   = wr_en && (addr == A_CTRL);
    reload_wr = wr_en && (addr == A_RELOAD);

    cmd.clear = ctrl_wr && !wdata[B_CLRN];
    cmd.load  = ctrl_wr && wdata[B_CLRN] && wdata[B_RUN] && !run_q;

    reload_d = reload_wr ? wdata : reload_q;
    run_d    = ctrl_wr ? wdata[B_RUN] : run_q;

    // hardware set outranks software clear
    if (underflow)
      flag_d = 1'b1;
    else if (ctrl_wr && !wdata[B_FLAG])
      flag_d = 1'b0;
    else
      flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      run_q    <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      reload_q <= reload_d;
      run_q    <= run_d;
      flag_q   <= flag_d;
    end
  end
endmodule

// File: rtl/timer_core.sv
module timer_core
  import timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_q,
  input  logic             tick,
  input  core_cmd_t        cmd,
  input  logic [CNT_W-1:0] reload_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             baud_q,
  output logic             underflow
);
  logic             step;
  logic             at_zero;
  logic [CNT_W-1:0] cnt_d;
  logic             baud_d;

  always_comb begin
    step      = run_q && tick && !cmd.clear;
    at_zero   = (cnt_q == '0);
    underflow = step && at_zero;

    cnt_d  = cnt_q;
    baud_d = baud_q;
    if (cmd.clear) begin
      cnt_d  = '0;
      baud_d = 1'b0;
    end else if (cmd.load) begin
      cnt_d = reload_q;
    end else if (step) begin
      if (at_zero) begin
        cnt_d  = reload_q;   // registered value: a same-cycle write waits
        baud_d = !baud_q;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      baud_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      baud_q <= baud_d;
    end
  end
endmodule

// File: rtl/timer_rdmux.sv
module timer_rdmux
  import timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  reload_q,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic              run_q,
  input  logic              flag_q,
  output logic [CNT_W-1:0]  rdata
);
  logic [CNT_W-1:0] ctrl_word;

  always_comb begin
    ctrl_word         = '0;
    ctrl_word[B_RUN]  = run_q;
    ctrl_word[B_CLRN] = 1'b1;
    ctrl_word[B_FLAG] = flag_q;
    case (addr)
      A_RELOAD: rdata = reload_q;
      A_COUNT:  rdata = cnt_q;
      A_CTRL:   rdata = ctrl_word;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/baud_reload_timer.sv
module baud_reload_timer
  import timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  input  logic              tick,
  output logic [CNT_W-1:0]  rdata,
  output logic              baud_clk,
  output logic              uflow_flag
);
  logic             rst_sync_n;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             flag_q;
  logic             underflow;
  core_cmd_t        cmd;

  timer_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  timer_regs #(.CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .underflow (underflow),
    .reload_q  (reload_q),
    .run_q     (run_q),
    .flag_q    (flag_q),
    .cmd       (cmd)
  );

  timer_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .run_q     (run_q),
    .tick      (tick),
    .cmd       (cmd),
    .reload_q  (reload_q),
    .cnt_q     (cnt_q),
    .baud_q    (baud_clk),
    .underflow (underflow)
  );

  timer_rdmux #(.CNT_W(CNT_W)) u_rd (
    .addr     (addr),
    .reload_q (reload_q),
    .cnt_q    (cnt_q),
    .run_q    (run_q),
    .flag_q   (flag_q),
    .rdata    (rdata)
  );

  assign uflow_flag = flag_q;
endmodule

// File: rtl/timer_checker.sv
module timer_checker
  import timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [CNT_W-1:0]  wdata,
  input logic              tick,
  input logic [CNT_W-1:0]  rdata,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  reload_q,
  input logic              run_q,
  input logic              baud_clk,
  input logic              uflow_flag
);
  logic cw, clr, uf;
  assign cw  = wr_en && (addr == A_CTRL);
  assign clr = cw && !wdata[B_CLRN];
  assign uf  = run_q && tick && !clr && (cnt_q == '0);

  p_step_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick && !clr && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  p_refill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    uf |=> (baud_clk != $past(baud_clk)) && uflow_flag);

  p_old_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    uf |=> (cnt_q == $past(reload_q)));

  p_start_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cw && wdata[B_RUN] && wdata[B_CLRN] && !run_q) |=> (cnt_q == $past(reload_q)));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !cw) |=> $stable(cnt_q));

  p_clear_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0) && !baud_clk);

  p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cw && !wdata[B_FLAG] && !uf) |=> !uflow_flag);

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (uflow_flag && !(cw && !wdata[B_FLAG])) |=> uflow_flag);

  p_clrn_reads_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_CTRL) |-> (rdata[B_CLRN] && rdata[4:3] == 2'b00));
endmodule

bind baud_reload_timer timer_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .wr_en      (wr_en),
  .addr       (addr),
  .wdata      (wdata),
  .tick       (tick),
  .rdata      (rdata),
  .cnt_q      (cnt_q),
  .reload_q   (reload_q),
  .run_q      (run_q),
  .baud_clk   (baud_clk),
  .uflow_flag (uflow_flag)
);

// File: tb/sim_baud_reload_timer.sv
`timescale 1ns/1ps
module sim_baud_reload_timer;
  localparam int W = 16;
  localparam logic [1:0] AR = 2'd0, AC = 2'd1, AK = 2'd2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [W-1:0] wdata = '0;
  logic tick = 1'b0;
  logic [W-1:0] rdata;
  logic baud_clk, uflow_flag;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  baud_reload_timer #(.CNT_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .tick(tick), .rdata(rdata), .baud_clk(baud_clk), .uflow_flag(uflow_flag)
  );

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // one clock cycle of stimulus, results visible on return
  task automatic cyc(input bit we, input logic [1:0] a, input int d, input bit tk);
    @(negedge clk);
    wr_en = we; addr = a; wdata = W'(d); tick = tk;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    addr = a;
    #0.5;
    v = int'(rdata);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, AR, 0, 1'b1);
  endtask

  initial begin
    #(4.0 * 200000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int v, held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state, R9 control readback
    rd(AR, v); chk("R1 reload", v, 0);
    rd(AC, v); chk("R1 count", v, 0);
    rd(AK, v); chk("R9 ctrl after reset", v, 2);
    chk("R1 baud", baud_clk, 0);
    chk("R1 flag", uflow_flag, 0);

    // R2/R3/R5 sweep over reload values
    for (int n = 0; n < 8; n++) begin
      cyc(1'b1, AR, n, 1'b0);
      cyc(1'b1, AK, 2, 1'b0);           // stop, flag clear
      cyc(1'b1, AK, 0, 1'b0);           // clear while stopped
      rd(AC, v); chk("R5 clear count", v, 0);
      chk("R5 clear baud", baud_clk, 0);
      cyc(1'b1, AK, 3, 1'b0);           // start with clear bit high
      rd(AC, v); chk("R3 start load", v, n);
      for (int k = 1; k <= 2 * (n + 1) + 1; k++) begin
        ticks(1);
        rd(AC, v); chk("R2 count", v, n - (k % (n + 1)));
        chk("R2 baud", baud_clk, (k / (n + 1)) % 2);
        chk("R2 flag", uflow_flag, (k >= n + 1) ? 1 : 0);
      end
    end

    // R4 stop holds, R10 ticks ignored while stopped
    rd(AC, held);
    cyc(1'b1, AK, 2, 1'b0);
    rd(AC, v); chk("R4 hold after stop", v, held);
    ticks(5);
    rd(AC, v); chk("R10 ticks ignored", v, held);
    rd(AK, v); chk("R4 run bit low", v & 1, 0);

    // R6 clear + start from stopped
    cyc(1'b1, AR, 5, 1'b0);
    cyc(1'b1, AK, 1, 1'b0);
    rd(AC, v); chk("R6 cleared", v, 0);
    chk("R6 baud low", baud_clk, 0);
    ticks(1);
    rd(AC, v); chk("R6 immediate refill", v, 5);
    chk("R6 baud high", baud_clk, 1);
    chk("R6 flag set", uflow_flag, 1);

    // R7 flag write semantics
    cyc(1'b1, AK, 7, 1'b0);
    chk("R7 write one keeps flag", uflow_flag, 1);
    cyc(1'b1, AK, 3, 1'b0);
    chk("R7 write zero clears", uflow_flag, 0);
    ticks(5);
    rd(AC, v); chk("R7 at zero", v, 0);
    cyc(1'b1, AK, 3, 1'b1);             // clear request meets underflow
    chk("R7 set beats clear", uflow_flag, 1);
    rd(AC, v); chk("R7 refill", v, 5);
    chk("R7 baud toggled", baud_clk, 0);

    // R8 reload write meets refill
    cyc(1'b1, AR, 2, 1'b0);
    ticks(5);
    rd(AC, v); chk("R8 at zero", v, 0);
    cyc(1'b1, AR, 6, 1'b1);
    rd(AC, v); chk("R8 old value used", v, 2);
    rd(AR, v); chk("R8 register updated", v, 6);
    ticks(3);
    rd(AC, v); chk("R8 new value next refill", v, 6);

    // R5 clear beats refill and count
    ticks(6);
    rd(AC, v); chk("R5 at zero", v, 0);
    cyc(1'b1, AK, 1, 1'b1);
    rd(AC, v); chk("R5 clear beats refill", v, 0);
    chk("R5 baud cleared", baud_clk, 0);
    chk("R5 no flag set", uflow_flag, 0);
    ticks(1);
    rd(AC, v); chk("R5 resumes", v, 6);
    cyc(1'b1, AK, 1, 1'b1);
    rd(AC, v); chk("R5 clear beats count", v, 0);

    // R9 reserved bits ignored
    ticks(2);
    rd(AC, held);
    cyc(1'b1, AK, 'h1B, 1'b0);
    rd(AK, v); chk("R9 reserved read zero", v, 3);
    rd(AC, v); chk("R9 no side effect", v, held);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule